// File: doc/BRIEF.md
# Shared Sum-of-Products Arithmetic Unit

This block returns one of four arithmetic results, picked by a two-bit select code. The four results are a product, a multiply-accumulate, a sum and a difference. The four operations are never needed together, so the block does not build four separate units and pick one of their outputs. It builds only the largest structure, a multiply-accumulate. That structure has three parts: a partial-product generator, a carry-save reduction stage and a final carry-propagate adder.

Steering logic in front of each part routes the selected operands through this single path:

- For the two multiply cases, the generator sees the chosen multiplier pair, and one extra row carries the addend, or zero for the plain product.
- For the sum and difference cases, the generator is gated off. The two addends then take the places of the first partial-product row and the addend row.
- For subtraction, the second operand is inverted across the full result width and a carry-in of one is injected.

All operands are unsigned and N bits wide. The result is 2N+1 bits wide and is held in one output register. A result therefore appears on the cycle after its operands and select are presented, and a new operation may be issued every cycle.

Top module: `shared_sop_unit`

## Requirements
- R1: With select code 0, the result one clock edge later equals the exact product a*b, zero-extended to 2N+1 bits.
- R2: With select code 1, the result one clock edge later equals the exact value c*d+e.
- R3: With select code 2, the result one clock edge later equals f+g. The carry out appears in bit N, and every bit above bit N is zero.
- R4: With select code 3, the result one clock edge later equals h-k modulo 2^(2N+1). When k exceeds h, the result is a two's-complement negative value whose top bit (bit 2N) is one.
- R5: Operands that the selected code does not use have no effect on the result.
- R6: While rst_n is low, the result is zero.
- R7: The select code and operands may change on every cycle. Each result corresponds to the inputs sampled at the preceding rising edge, with no stall or hold.
- R8: Extreme operands give exact results with N=8: all-ones multiply gives 65025, all-ones multiply-accumulate gives 65280, all-ones sum gives 510, 0 minus 255 gives 130817, and equal operands subtracted give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Operation code: 0 product, 1 multiply-accumulate, 2 sum, 3 difference |
| a | input | N | Product multiplicand |
| b | input | N | Product multiplier |
| c | input | N | Multiply-accumulate multiplicand |
| d | input | N | Multiply-accumulate multiplier |
| e | input | N | Multiply-accumulate addend |
| f | input | N | Sum first operand |
| g | input | N | Sum second operand |
| h | input | N | Difference minuend |
| k | input | N | Difference subtrahend |
| result | output | 2N+1 | Registered result of the selected operation |

## Verification
The hardest condition to reach from the ports is a long carry ripple through the whole width of the final adder. This happens when an inverted subtrahend fills the upper bits with ones and must be cancelled exactly by the injected carry, as in h equal to k or h equal to zero. Random operands rarely hit it, so directed items cover all-ones and all-zero subtraction, equal operands, and all-ones multiply and accumulate. Random items then switch the select code on every cycle, so a steering choice left over from the previous operation would corrupt the next result. Separate runs hold the used operands fixed while scrambling every unused one.

// File: rtl/sop_share_pkg.sv
package sop_share_pkg;

    typedef enum logic [1:0] {
        SEL_MUL = 2'd0,
        SEL_MAC = 2'd1,
        SEL_ADD = 2'd2,
        SEL_SUB = 2'd3
    } sel_e;

endpackage

// File: rtl/sop_operand_steer.sv
module sop_operand_steer
    import sop_share_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 2 * N + 1
) (
    input  logic [1:0]   sel,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] c,
    input  logic [N-1:0] d,
    input  logic [N-1:0] e,
    input  logic [N-1:0] f,
    input  logic [N-1:0] g,
    input  logic [N-1:0] h,
    input  logic [N-1:0] k,
    output logic [N-1:0] mul_x,
    output logic [N-1:0] mul_y,
    output logic         pp_en,
    output logic [W-1:0] alt_row,
    output logic [W-1:0] add_row,
    output logic         carry_in
);

    always_comb begin
        mul_x    = '0;
        mul_y    = '0;
        pp_en    = 1'b0;
        alt_row  = '0;
        add_row  = '0;
        carry_in = 1'b0;
        unique case (sel_e'(sel))
            SEL_MUL: begin
                mul_x = a;
                mul_y = b;
                pp_en = 1'b1;
            end
            SEL_MAC: begin
                mul_x   = c;
                mul_y   = d;
                pp_en   = 1'b1;
                add_row = W'(e);
            end
            SEL_ADD: begin
                alt_row = W'(g);
                add_row = W'(f);
            end
            SEL_SUB: begin
                // full-width inversion so the upper bits become ones
                alt_row  = ~W'(k);
                add_row  = W'(h);
                carry_in = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sop_ppgen.sv
module sop_ppgen #(
    parameter int N = 8,
    parameter int W = 2 * N + 1
) (
    input  logic [N-1:0]        mul_x,
    input  logic [N-1:0]        mul_y,
    input  logic                pp_en,
    output logic [N-1:0][W-1:0] pp_rows
);

    for (genvar i = 0; i < N; i++) begin : g_row
        assign pp_rows[i] = (pp_en && mul_y[i]) ? (W'(mul_x) << i) : '0;
    end

endmodule

// File: rtl/sop_csa_tree.sv
module sop_csa_tree #(
    parameter int W    = 17,
    parameter int ROWS = 9
) (
    input  logic [ROWS-1:0][W-1:0] rows,
    output logic [W-1:0]           sum_vec,
    output logic [W-1:0]           carry_vec
);

    localparam int STAGES = ROWS - 2;

    for (genvar j = 0; j < STAGES; j++) begin : g_csa
        logic [W-1:0] s_in;
        logic [W-1:0] c_in;
        logic [W-1:0] x_in;
        logic [W-1:0] maj;
        logic [W-1:0] s_o;
        logic [W-1:0] c_o;

        if (j == 0) begin : g_first
            assign s_in = rows[0];
            assign c_in = rows[1];
        end else begin : g_next
            assign s_in = g_csa[j-1].s_o;
            assign c_in = g_csa[j-1].c_o;
        end

        assign x_in = rows[j+2];
        assign s_o  = s_in ^ c_in ^ x_in;
        assign maj  = (s_in & c_in) | (s_in & x_in) | (c_in & x_in);
        assign c_o  = maj << 1;
    end

    assign sum_vec   = g_csa[STAGES-1].s_o;
    assign carry_vec = g_csa[STAGES-1].c_o;

endmodule

// File: rtl/sop_cpa.sv
module sop_cpa #(
    parameter int W = 17
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         carry_in,
    output logic [W-1:0] z
);

    logic [W-1:0] cy;

    assign cy[0] = carry_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign z[i] = x[i] ^ y[i] ^ cy[i];
        if (i < W - 1) begin : g_carry
            assign cy[i+1] = (x[i] & y[i]) | (x[i] & cy[i]) | (y[i] & cy[i]);
        end
    end

endmodule

// File: rtl/shared_sop_unit.sv
module shared_sop_unit
    import sop_share_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     b,
    input  logic [N-1:0]     c,
    input  logic [N-1:0]     d,
    input  logic [N-1:0]     e,
    input  logic [N-1:0]     f,
    input  logic [N-1:0]     g,
    input  logic [N-1:0]     h,
    input  logic [N-1:0]     k,
    output logic [2*N:0]     result
);

    localparam int W    = 2 * N + 1;
    localparam int ROWS = N + 1;

    typedef struct packed {
        logic         vld;
        logic [1:0]   sel;
        logic [W-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]          mul_x, mul_y;
    logic                  pp_en;
    logic [W-1:0]          alt_row, add_row;
    logic                  carry_in;
    logic [N-1:0][W-1:0]   pp_rows;
    logic [ROWS-1:0][W-1:0] tree_rows;
    logic [W-1:0]          sum_vec, carry_vec, cpa_out;

    sop_operand_steer #(.N(N), .W(W)) u_steer (
        .sel      (sel),
        .a        (a),
        .b        (b),
        .c        (c),
        .d        (d),
        .e        (e),
        .f        (f),
        .g        (g),
        .h        (h),
        .k        (k),
        .mul_x    (mul_x),
        .mul_y    (mul_y),
        .pp_en    (pp_en),
        .alt_row  (alt_row),
        .add_row  (add_row),
        .carry_in (carry_in)
    );

    sop_ppgen #(.N(N), .W(W)) u_ppgen (
        .mul_x   (mul_x),
        .mul_y   (mul_y),
        .pp_en   (pp_en),
        .pp_rows (pp_rows)
    );

    // row 0 is shared: first partial product or the second addend
    always_comb begin
        for (int i = 0; i < N; i++) begin
            tree_rows[i] = pp_rows[i];
        end
        if (!pp_en) begin
            tree_rows[0] = alt_row;
        end
        tree_rows[N] = add_row;
    end

    sop_csa_tree #(.W(W), .ROWS(ROWS)) u_tree (
        .rows      (tree_rows),
        .sum_vec   (sum_vec),
        .carry_vec (carry_vec)
    );

    sop_cpa #(.W(W)) u_cpa (
        .x        (sum_vec),
        .y        (carry_vec),
        .carry_in (carry_in),
        .z        (cpa_out)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b1;
        st_d.sel = sel;
        st_d.res = cpa_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;

    // R1
    mul_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.sel == SEL_MUL) |-> st_q.res == W'($past(a)) * W'($past(b)));

    // R2
    mac_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.sel == SEL_MAC)
            |-> st_q.res == W'($past(c)) * W'($past(d)) + W'($past(e)));

    // R3
    add_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.sel == SEL_ADD)
            |-> (st_q.res[W-1:N+1] == '0 && st_q.res == W'($past(f)) + W'($past(g))));

    // R4
    sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.sel == SEL_SUB) |-> st_q.res == W'($past(h)) - W'($past(k)));

    // R4
    sub_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.sel == SEL_SUB && $past(k) > $past(h)) |-> st_q.res[W-1]);

endmodule

// File: tb/sim_shared_sop_unit.sv
module sim_shared_sop_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int W = 2 * N + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   sel = '0;
    logic [N-1:0] a = '0, b = '0, c = '0, d = '0, e = '0;
    logic [N-1:0] f = '0, g = '0, h = '0, k = '0;
    logic [W-1:0] result;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [W-1:0] exp;
        string        req;
    } item_t;

    item_t sb_q[$];

    shared_sop_unit #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .a(a), .b(b), .c(c), .d(d), .e(e),
        .f(f), .g(g), .h(h), .k(k),
        .result(result)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [W-1:0] ref_model(input logic [1:0] s,
        input logic [N-1:0] ia, ib, ic, id, ie, iff_, ig, ih, ik);
        logic [W-1:0] r;
        case (s)
            2'd0:    r = W'(ia) * W'(ib);
            2'd1:    r = W'(ic) * W'(id) + W'(ie);
            2'd2:    r = W'(iff_) + W'(ig);
            default: r = W'(ih) - W'(ik);
        endcase
        return r;
    endfunction

    task automatic drive(input logic [1:0] s,
        input logic [N-1:0] ia, ib, ic, id, ie, iff_, ig, ih, ik,
        input string req);
        item_t it;
        @(negedge clk);
        sel = s; a = ia; b = ib; c = ic; d = id; e = ie;
        f = iff_; g = ig; h = ih; k = ik;
        it.exp = ref_model(s, ia, ib, ic, id, ie, iff_, ig, ih, ik);
        it.req = req;
        sb_q.push_back(it);
    endtask

    function automatic logic [N-1:0] rnd();
        return N'($urandom);
    endfunction

    // monitor: result of the item pushed before edge t is checked just after t
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (result !== it.exp) begin
                    bad++;
                    $display("FAIL %s: result=%0d expected=%0d", it.req, result, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: result=%0d expected=completion", result);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R6: reset holds result at zero even with busy inputs
        @(negedge clk);
        sel = 2'd1; c = 8'hff; d = 8'hff; e = 8'hff;
        repeat (2) @(negedge clk);
        total++;
        if (result !== '0) begin
            bad++;
            $display("FAIL R6: result=%0d expected=0", result);
        end
        rst_n = 1'b1;

        // R8 corners
        drive(2'd0, 8'hff, 8'hff, 0, 0, 0, 0, 0, 0, 0, "R8 mul all-ones");
        drive(2'd1, 0, 0, 8'hff, 8'hff, 8'hff, 0, 0, 0, 0, "R8 mac all-ones");
        drive(2'd2, 0, 0, 0, 0, 0, 8'hff, 8'hff, 0, 0, "R8 add all-ones");
        drive(2'd3, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'hff, "R8 sub 0-255");
        drive(2'd3, 0, 0, 0, 0, 0, 0, 0, 8'h5a, 8'h5a, "R8 sub equal");
        drive(2'd3, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R8 sub zero");
        drive(2'd3, 0, 0, 0, 0, 0, 0, 0, 8'hff, 8'h01, "R4 sub positive");
        drive(2'd3, 0, 0, 0, 0, 0, 0, 0, 8'h01, 8'h02, "R4 sub minus one");
        drive(2'd0, 8'h00, 8'hff, 0, 0, 0, 0, 0, 0, 0, "R1 mul by zero");
        drive(2'd1, 0, 0, 8'h00, 8'h00, 8'hff, 0, 0, 0, 0, "R2 mac addend only");
        drive(2'd2, 0, 0, 0, 0, 0, 8'h80, 8'h80, 0, 0, "R3 add carry out");

        // R1..R4 per code
        for (int i = 0; i < 100; i++)
            drive(2'd0, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), "R1 mul");
        for (int i = 0; i < 100; i++)
            drive(2'd1, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), "R2 mac");
        for (int i = 0; i < 100; i++)
            drive(2'd2, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), "R3 add");
        for (int i = 0; i < 100; i++)
            drive(2'd3, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), "R4 sub");

        // R5: fixed used operands, unused ones scrambled every cycle
        for (int i = 0; i < 40; i++)
            drive(2'd0, 8'h0d, 8'h13, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), "R5 mul unused");
        for (int i = 0; i < 40; i++)
            drive(2'd2, rnd(), rnd(), rnd(), rnd(), rnd(), 8'h21, 8'hc4, rnd(), rnd(), "R5 add unused");
        for (int i = 0; i < 40; i++)
            drive(2'd3, rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), 8'h40, 8'h41, "R5 sub unused");

        // R7: select changes on every cycle
        for (int i = 0; i < 400; i++)
            drive(2'($urandom), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(),
                  "R7 back-to-back");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule